// File: doc/BRIEF.md
# Interrupt and Break Entry Sequencer

This block steps an 8-bit processor through entering an interrupt handler, one bus cycle per clock. It takes three kinds of entry. A maskable request is a level input and is honoured only while the interrupt-disable flag is clear. A non-maskable request is caught on its rising edge and held in a pending latch until it is served. A software break is requested by the instruction decoder. Each cycle the sequencer drives one bus address and either a read strobe or a write strobe. It pushes the return address and a packed status byte onto a stack that lives in a fixed page, sets the interrupt-disable flag, and then reads the 16-bit handler address from a vector pair.

The block is used while the core is idle between instructions. On a start it captures the program counter, the stack pointer and the status flags. It hands back the decremented stack pointer and the handler address as the new program counter. A done strobe marks the last cycle. A non-maskable request that arrives while a break is running can take over that break. The return address and the status byte (with B set) are already on the stack, but the handler is fetched from the non-maskable vector instead.

Top module: `irq_entry_seq`

## Requirements
- R1: A maskable or non-maskable entry takes seven bus cycles, starting the cycle after acceptance: two reads at the captured PC, a write of PC[15:8], a write of PC[7:0], a write of the status byte, a read of the vector low address, then a read of the vector high address.
- R2: Every stack write goes to address {8'h01, SP}, and SP decrements by one after each write, wrapping from 8'h00 to 8'hFF. After a sequence, sp_out equals the captured SP minus 3.
- R3: The pushed status byte is {N, V, 1, B, D, I, Z, C} from bit 7 down to bit 0, taken from flags_in at the same positions (flags_in bits 5 and 4 are ignored). B is 0 for hardware entries and 1 for a break. The return address bytes pushed are the captured PC (plus one for a break, see R6).
- R4: The pushed I bit is the value before entry. i_flag_out reads 1 from the clock edge that ends the status write, and stays 1 while idle.
- R5: Maskable and break entries read their vector from 16'hFFFE (low) and 16'hFFFF (high). Non-maskable entries read from 16'hFFFA and 16'hFFFB. Afterwards pc_out = {high byte, low byte}.
- R6: A break entry takes six cycles: one read at the captured PC, then the same push and vector steps. The return address pushed is the captured PC plus one (modulo 2^16).
- R7: If a non-maskable request is pending at the edge that ends a break's status write, it is cleared and the break fetches the non-maskable vector. No separate non-maskable entry follows for that request.
- R8: The non-maskable input is edge-detected. A level held high gives exactly one entry. A rising edge that arrives while a sequence runs (and is not taken over by R7) is served by its own entry afterwards.
- R9: When idle, the choice is made in this priority order: pending non-maskable first, then break request, then maskable request. A maskable request is ignored while flags_in bit 2 (I) is 1.
- R10: After reset, the block is idle with pc_out = 0, sp_out = 8'hFF, i_flag_out = 1 and no strobe active. done is high only in the vector-high cycle of each sequence. Read and write strobes are never active together, and neither is active while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 1 | Maskable request, level sensitive |
| nmi_in | input | 1 | Non-maskable request, rising edge sets pending |
| brk_req | input | 1 | Break entry request from decode |
| pc_in | input | 16 | Program counter captured at start |
| sp_in | input | 8 | Stack pointer captured at start |
| flags_in | input | 8 | Status flags captured at start, packed as in R3 |
| bus_rdata | input | 8 | Read data from the bus |
| bus_addr | output | 16 | Bus address for this cycle |
| bus_wdata | output | 8 | Write data for this cycle |
| bus_we | output | 1 | Write strobe |
| bus_rd | output | 1 | Read strobe |
| sp_out | output | 8 | Updated stack pointer |
| pc_out | output | 16 | Updated program counter |
| i_flag_out | output | 1 | Interrupt-disable flag |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | High in the vector-high cycle |

## Verification
The hardest case to reach is the takeover. A non-maskable edge must be latched before the edge that closes a break's status write, yet after the break has already been accepted. If it arrives too early, the non-maskable request wins at selection. If it arrives too late, it waits for its own entry. The stimulus raises the non-maskable input one cycle after a break is accepted to hit the takeover. A second run raises it after the status write to land in the deferred case. The bench model settles the vector choice itself at the status-write edge and compares every bus cycle.

// File: rtl/irq_entry_seq.sv
module irq_entry_seq #(
  parameter logic [7:0]  STACK_PAGE = 8'h01,
  parameter logic [15:0] MASK_VEC   = 16'hFFFE,
  parameter logic [15:0] NMI_VEC    = 16'hFFFA
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        irq_req,
  input  logic        nmi_in,
  input  logic        brk_req,
  input  logic [15:0] pc_in,
  input  logic [7:0]  sp_in,
  input  logic [7:0]  flags_in,
  input  logic [7:0]  bus_rdata,
  output logic [15:0] bus_addr,
  output logic [7:0]  bus_wdata,
  output logic        bus_we,
  output logic        bus_rd,
  output logic [7:0]  sp_out,
  output logic [15:0] pc_out,
  output logic        i_flag_out,
  output logic        busy,
  output logic        done
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_D0, ST_D1, ST_PH, ST_PL, ST_PS, ST_VL, ST_VH
  } st_t;

  st_t         st;
  logic [15:0] pc_r;
  logic [7:0]  sp_r, fl_r;
  logic        is_brk, use_nmi, nmi_q, nmi_pend;

  wire nmi_rise  = nmi_in & ~nmi_q;
  wire grab_nmi  = (st == ST_IDLE) & nmi_pend;
  wire steal_nmi = (st == ST_PS) & is_brk & nmi_pend;
  wire irq_ok    = irq_req & ~flags_in[2];

  wire [15:0] vec_base = use_nmi ? NMI_VEC : MASK_VEC;
  wire [7:0]  status   = {fl_r[7:6], 1'b1, is_brk, fl_r[3:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      pc_r     <= '0;
      sp_r     <= 8'hFF;
      fl_r     <= 8'h04;
      is_brk   <= 1'b0;
      use_nmi  <= 1'b0;
      nmi_q    <= 1'b0;
      nmi_pend <= 1'b0;
    end else begin
      nmi_q    <= nmi_in;
      nmi_pend <= (nmi_pend & ~(grab_nmi | steal_nmi)) | nmi_rise;
      case (st)
        ST_IDLE: begin
          if (nmi_pend || brk_req || irq_ok) begin
            pc_r    <= pc_in;
            sp_r    <= sp_in;
            fl_r    <= flags_in;
            use_nmi <= nmi_pend;
            is_brk  <= ~nmi_pend & brk_req;
            st      <= (~nmi_pend & brk_req) ? ST_D1 : ST_D0;
          end
        end
        ST_D0: st <= ST_D1;
        ST_D1: begin
          if (is_brk) pc_r <= pc_r + 16'd1;
          st <= ST_PH;
        end
        ST_PH: begin
          sp_r <= sp_r - 8'd1;
          st   <= ST_PL;
        end
        ST_PL: begin
          sp_r <= sp_r - 8'd1;
          st   <= ST_PS;
        end
        ST_PS: begin
          sp_r    <= sp_r - 8'd1;
          fl_r[2] <= 1'b1;
          if (steal_nmi) use_nmi <= 1'b1;
          st      <= ST_VL;
        end
        ST_VL: begin
          pc_r[7:0] <= bus_rdata;
          st        <= ST_VH;
        end
        ST_VH: begin
          pc_r[15:8] <= bus_rdata;
          st         <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    bus_addr  = pc_r;
    bus_wdata = 8'h00;
    case (st)
      ST_PH: begin bus_addr = {STACK_PAGE, sp_r}; bus_wdata = pc_r[15:8]; end
      ST_PL: begin bus_addr = {STACK_PAGE, sp_r}; bus_wdata = pc_r[7:0];  end
      ST_PS: begin bus_addr = {STACK_PAGE, sp_r}; bus_wdata = status;     end
      ST_VL: bus_addr = vec_base;
      ST_VH: bus_addr = vec_base | 16'h0001;
      default: ;
    endcase
  end

  assign bus_we     = (st == ST_PH) | (st == ST_PL) | (st == ST_PS);
  assign bus_rd     = (st == ST_D0) | (st == ST_D1) | (st == ST_VL) | (st == ST_VH);
  assign done       = (st == ST_VH);
  assign busy       = (st != ST_IDLE);
  assign sp_out     = sp_r;
  assign pc_out     = pc_r;
  assign i_flag_out = fl_r[2];

  p_sp_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we |=> (sp_out == $past(sp_out) - 8'd1));

  p_iflag_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && st == ST_PS) |=> i_flag_out);

  p_vec_hi_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (pc_out[15:8] == $past(bus_rdata)));

  p_steal_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (steal_nmi && !nmi_rise) |=> (!nmi_pend && bus_addr == NMI_VEC));

  p_irq_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && !nmi_pend && !brk_req && irq_req && flags_in[2]) |=> !busy);

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bus_we, bus_rd}) && (busy || (!bus_we && !bus_rd)));

endmodule

// File: tb/test_irq_entry_seq.sv
module test_irq_entry_seq;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic irq_req = 0, nmi_in = 0, brk_req = 0;
  logic [15:0] pc_in = '0;
  logic [7:0]  sp_in = '0, flags_in = '0;
  logic [7:0]  bus_rdata;
  logic [15:0] bus_addr, pc_out;
  logic [7:0]  bus_wdata, sp_out;
  logic bus_we, bus_rd, i_flag_out, busy, done;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] mem_f(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction
  assign bus_rdata = mem_f(bus_addr);

  irq_entry_seq i_irq_entry_seq (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .nmi_in(nmi_in), .brk_req(brk_req),
    .pc_in(pc_in), .sp_in(sp_in), .flags_in(flags_in), .bus_rdata(bus_rdata),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_rd(bus_rd),
    .sp_out(sp_out), .pc_out(pc_out), .i_flag_out(i_flag_out), .busy(busy), .done(done));

  typedef struct { bit we; logic [15:0] addr; logic [7:0] data; } op_t;
  op_t q[$];
  bit m_pend, m_prev, m_brk, finished;
  logic [15:0] exp_pc;
  logic [7:0]  exp_sp;
  bit exp_i;
  int n_cmp = 0, n_bad = 0;
  string scen = "init";

  task automatic cmp(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s (%s) t=%0t: actual %h expected %h", tag, scen, $time, act, exp);
    end
  endtask

  function automatic void add_op(input bit we, input logic [15:0] a, input logic [7:0] d);
    op_t o;
    o.we = we; o.addr = a; o.data = d;
    q.push_back(o);
  endfunction

  function automatic void build(input bit brk, input bit nmi);
    logic [15:0] pc = pc_in;
    logic [7:0]  sp = sp_in;
    logic [15:0] vec = nmi ? 16'hFFFA : 16'hFFFE;
    if (!brk) add_op(0, pc, 0);
    add_op(0, pc, 0);
    if (brk) pc = pc + 16'd1;
    add_op(1, {8'h01, sp}, pc[15:8]); sp = sp - 8'd1;
    add_op(1, {8'h01, sp}, pc[7:0]);  sp = sp - 8'd1;
    add_op(1, {8'h01, sp}, {flags_in[7:6], 1'b1, brk, flags_in[3:0]}); sp = sp - 8'd1;
    add_op(0, vec, 0);
    add_op(0, vec + 16'd1, 0);
    m_brk  = brk;
    exp_pc = {mem_f(vec + 16'd1), mem_f(vec)};
    exp_sp = sp;
    exp_i  = 1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); m_pend = 0; m_prev = 0; m_brk = 0;
      exp_pc = 16'h0000; exp_sp = 8'hFF; exp_i = 1;
    end else begin
      bit rise, take;
      rise = nmi_in && !m_prev;
      m_prev = nmi_in;
      take = 0;
      if (q.size() > 0) begin
        if (q.size() == 3 && m_brk && m_pend) begin
          take = 1;
          q[1].addr = 16'hFFFA;
          q[2].addr = 16'hFFFB;
          exp_pc = {mem_f(16'hFFFB), mem_f(16'hFFFA)};
        end
        void'(q.pop_front());
      end else if (m_pend) begin
        take = 1; build(0, 1);
      end else if (brk_req) build(1, 0);
      else if (irq_req && !flags_in[2]) build(0, 0);
      m_pend = (m_pend && !take) || rise;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (q.size() > 0) begin
        cmp("R1 addr", bus_addr, q[0].addr);
        cmp("R1 we", {15'd0, bus_we}, {15'd0, q[0].we});
        cmp("R1 rd", {15'd0, bus_rd}, {15'd0, !q[0].we});
        if (q[0].we) cmp("R3 wdata", {8'd0, bus_wdata}, {8'd0, q[0].data});
        cmp("R10 done", {15'd0, done}, {15'd0, q.size() == 1});
      end else begin
        cmp("R10 idle strobes", {14'd0, bus_we, bus_rd}, 16'd0);
        cmp("R10 idle done", {15'd0, done}, 16'd0);
        cmp("R5 pc_out", pc_out, exp_pc);
        cmp("R2 sp_out", {8'd0, sp_out}, {8'd0, exp_sp});
        cmp("R4 i_flag", {15'd0, i_flag_out}, {15'd0, exp_i});
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setup(input logic [15:0] pc, input logic [7:0] sp, input logic [7:0] fl);
    pc_in = pc; sp_in = sp; flags_in = fl;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      finished = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired (%s)", scen);
      summary();
      $finish;
    end
  end

  initial begin
    cyc(5);
    rst_n = 1;
    scen = "R10 reset"; cyc(3);

    scen = "R1 maskable entry";
    setup(16'h1234, 8'hFD, 8'hCB);
    irq_req = 1; cyc(1); irq_req = 0; cyc(10);

    scen = "R9 masked request";
    setup(16'h4444, 8'h40, 8'h04);
    irq_req = 1; cyc(3); irq_req = 0; cyc(4);

    scen = "R8 held nmi level";
    setup(16'hABCD, 8'h80, 8'h00);
    nmi_in = 1; cyc(20); nmi_in = 0; cyc(4);

    scen = "R6 plain break";
    setup(16'h2000, 8'h10, 8'hF3);
    brk_req = 1; cyc(1); brk_req = 0; cyc(10);

    scen = "R7 nmi takes over break";
    setup(16'h3456, 8'h77, 8'h41);
    brk_req = 1; cyc(1); brk_req = 0; nmi_in = 1; cyc(2); nmi_in = 0; cyc(12);

    scen = "R8 late nmi after break push";
    setup(16'h5000, 8'h60, 8'h80);
    brk_req = 1; cyc(1); brk_req = 0; cyc(4); nmi_in = 1; cyc(1); nmi_in = 0; cyc(18);

    scen = "R9 priority nmi over break and irq";
    setup(16'h6000, 8'h50, 8'h00);
    nmi_in = 1; cyc(1); brk_req = 1; irq_req = 1; cyc(1);
    brk_req = 0; irq_req = 0; nmi_in = 0; cyc(10);

    scen = "R9 priority break over irq";
    setup(16'h7000, 8'h30, 8'h00);
    brk_req = 1; irq_req = 1; cyc(1); brk_req = 0; irq_req = 0; cyc(10);

    scen = "R2 stack wrap and pc wrap";
    setup(16'hFFFF, 8'h01, 8'h00);
    brk_req = 1; cyc(1); brk_req = 0; cyc(10);

    scen = "R3 irq status bits";
    setup(16'h0102, 8'h00, 8'h3A);
    irq_req = 1; cyc(1); irq_req = 0; cyc(10);

    finished = 1;
    summary();
    $finish;
  end
endmodule